// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a serial memory interface. It collects the data bytes of one write transaction into a page-sized staging buffer, then writes them into a 256 x 8 array. The array is split into 16 pages of 16 bytes. The bus logic upstream reports four things: where a transaction begins, each received data byte, the stop condition, and an abort. A protection unit supplies a permit signal for the address being written.

Each staging entry carries a valid bit. When a stop arrives, the entries that were loaded are written to the array in one self-timed programming cycle. The busy output stays high for that whole cycle, and every input is ignored until it ends. The cycle length is the parameter `CYCLE_CLKS`, counted in system clocks.

The controller has four states:

- `ST_IDLE` waits for a transaction start.
- `ST_COLLECT` loads bytes into the buffer.
- `ST_COMMIT` walks the 16 entries, one per clock.
- `ST_HOLD` waits out the rest of the timed cycle.

Transitions:

- IDLE to COLLECT on start.
- COLLECT back to COLLECT on a repeated start.
- COLLECT to IDLE on abort, or on a stop with no data.
- COLLECT to COMMIT on a stop with data.
- COMMIT to HOLD after the last entry.
- COMMIT to IDLE directly, if the count is already spent.
- HOLD to IDLE when the count expires.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: A byte taken while collecting is staged at offset p, and is later written at array address {start_addr[7:4], p}. The first byte has p = start_addr[3:0]. Each further byte adds one to p modulo 16, so the page nibble never changes.
- R3: When more than 16 bytes arrive, p wraps to the same page. The newest byte at an offset replaces any older one.
- R4: Only offsets that received a byte in the current transaction are written, each at most once per commit. Other addresses of the page keep their contents.
- R5: `busy` rises on the clock edge where `stop` is taken with data staged. During the following 16 cycles, offsets 0 to 15 are presented in ascending order, one per clock.
- R6: An entry is written (`mem_we` high) only if `wr_permit` is high in the cycle that presents it.
- R7: `busy` stays high for exactly `CYCLE_CLKS` clocks, where `CYCLE_CLKS` >= 16.
- R8: While `busy` is high, `txn_start`, `byte_vld`, `stop` and `abort` have no effect.
- R9: An abort, or a stop with no byte staged, commits nothing and leaves `busy` low.
- R10: A byte presented in the same cycle as `stop` is included in the commit.
- R11: A `txn_start` while collecting discards the staged bytes and takes a new start address.
- R12: `abort` in the same cycle as `stop` wins, and nothing is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Begins a write transaction at `start_addr` |
| start_addr | input | 8 | First array address of the transaction |
| byte_vld | input | 1 | Strobe: one data byte received |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Stop condition, which requests the commit |
| abort | input | 1 | Drops the transaction |
| wr_permit | input | 1 | Permission for the address on `mem_waddr` |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The last data byte and the stop condition can land in the same clock. So can an abort and a stop. The bench raises `byte_vld` together with `stop` and checks that the byte still appears in the committed page (R10). It raises `abort` together with `stop` and checks that `busy` never rises and no array write occurs (R12). Beyond these two collisions, an exhaustive sweep covers every start offset with byte counts of 1 to 20, under changing permit masks. The array image it builds from the observed writes must equal an arithmetically derived expectation.

// File: rtl/page_buf_pkg.sv
package page_buf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } pb_state_e;
endpackage

// File: rtl/page_buf_store.sv
module page_buf_store #(
    parameter int OFF_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    localparam int ENTRIES = 1 << OFF_W;

    logic [DATA_W-1:0] ent_data [ENTRIES];
    logic [ENTRIES-1:0] ent_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_vld <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_data[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (clr) begin
                    ent_vld[i] <= 1'b0;
                end else if (ld && (ld_off == OFF_W'(i))) begin
                    ent_vld[i]  <= 1'b1;
                    ent_data[i] <= ld_data;
                end
            end
        end
    end

    assign rd_data = ent_data[rd_off];
    assign rd_vld  = ent_vld[rd_off];
    assign any_vld = |ent_vld;
endmodule

// File: rtl/page_cycle_timer.sv
module page_cycle_timer #(
    parameter int CYCLE_CLKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (en)     cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/page_commit_fsm.sv
module page_commit_fsm
    import page_buf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    txn_start,
    input  logic [ADDR_W-1:0]       start_addr,
    input  logic                    byte_vld,
    input  logic                    stop,
    input  logic                    abort,
    input  logic                    any_vld,
    input  logic                    timer_done,
    output logic                    store_clr,
    output logic                    store_ld,
    output logic [OFF_W-1:0]        ld_off,
    output logic [OFF_W-1:0]        rd_off,
    output logic [ADDR_W-OFF_W-1:0] page,
    output logic                    committing,
    output logic                    busy,
    output logic                    timer_clr
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = '1;

    pb_state_e         state, state_nx;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  ptr_q;
    logic [OFF_W-1:0]  idx_q;
    logic              take_start;
    logic              go_commit;

    always_comb begin
        take_start = 1'b0;
        go_commit  = 1'b0;
        unique case (state)
            ST_IDLE:    take_start = txn_start;
            ST_COLLECT: begin
                take_start = txn_start && !abort;
                go_commit  = !abort && !txn_start && stop && (any_vld || byte_vld);
            end
            default: ;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (txn_start) state_nx = ST_COLLECT;
            ST_COLLECT: begin
                if (abort)          state_nx = ST_IDLE;
                else if (txn_start) state_nx = ST_COLLECT;
                else if (go_commit) state_nx = ST_COMMIT;
                else if (stop)      state_nx = ST_IDLE;
            end
            ST_COMMIT:  if (idx_q == LAST_OFF) state_nx = timer_done ? ST_IDLE : ST_HOLD;
            ST_HOLD:    if (timer_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (take_start) begin
                page_q <= start_addr[ADDR_W-1:OFF_W];
                ptr_q  <= start_addr[OFF_W-1:0];
            end else if (store_ld) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (go_commit)               idx_q <= '0;
            else if (state == ST_COMMIT) idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        store_clr  = take_start;
        store_ld   = (state == ST_COLLECT) && byte_vld && !abort && !txn_start;
        timer_clr  = go_commit;
        committing = (state == ST_COMMIT);
        busy       = (state == ST_COMMIT) || (state == ST_HOLD);
        ld_off     = ptr_q;
        rd_off     = idx_q;
        page       = page_q;
    end
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
    parameter int ADDR_W     = 8,
    parameter int OFF_W      = 4,
    parameter int DATA_W     = 8,
    parameter int CYCLE_CLKS = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop,
    input  logic              abort,
    input  logic              wr_permit,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              store_clr, store_ld, any_vld, rd_vld;
    logic [OFF_W-1:0]  ld_off, rd_off;
    logic [DATA_W-1:0] rd_data;
    logic [PAGE_W-1:0] page;
    logic              committing, timer_clr, timer_done;

    page_commit_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .start_addr (start_addr),
        .byte_vld   (byte_vld),
        .stop       (stop),
        .abort      (abort),
        .any_vld    (any_vld),
        .timer_done (timer_done),
        .store_clr  (store_clr),
        .store_ld   (store_ld),
        .ld_off     (ld_off),
        .rd_off     (rd_off),
        .page       (page),
        .committing (committing),
        .busy       (busy),
        .timer_clr  (timer_clr)
    );

    page_buf_store #(.OFF_W(OFF_W), .DATA_W(DATA_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (store_clr),
        .ld      (store_ld),
        .ld_off  (ld_off),
        .ld_data (byte_data),
        .rd_off  (rd_off),
        .rd_data (rd_data),
        .rd_vld  (rd_vld),
        .any_vld (any_vld)
    );

    page_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .en    (busy),
        .done  (timer_done)
    );

    assign mem_we    = committing && rd_vld && wr_permit;
    assign mem_waddr = {page, rd_off};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
    parameter int ADDR_W     = 8,
    parameter int CYCLE_CLKS = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop,
    input logic              abort,
    input logic              wr_permit,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R8
    AST_WE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_permit); // R6
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop) && !$past(abort))); // R12
    AST_ASCENDING_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(busy)) |-> (mem_waddr == $past(mem_waddr) + 1'b1)); // R5
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == CYCLE_CLKS)); // R7
endmodule

bind page_commit_buf page_commit_chk #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYCLE_CLKS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (stop),
    .abort     (abort),
    .wr_permit (wr_permit),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr)
);

// File: tb/test_page_commit_buf.sv
module test_page_commit_buf;
    localparam int CYC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0;
    logic [7:0] start_addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop = 1'b0;
    logic       abort = 1'b0;
    logic       wr_permit;
    logic       busy, mem_we;
    logic [7:0] mem_waddr, mem_wdata;

    logic [15:0] deny = '0;
    logic [7:0]  shadow [256];
    logic [7:0]  expm   [256];
    int          n_checks = 0;
    int          n_errors = 0;
    int          wr_cnt = 0;
    int          prev_off = -1;
    int          order_bad = 0;

    always #2.5 clk = ~clk;

    assign wr_permit = ~deny[mem_waddr[3:0]];

    page_commit_buf #(.CYCLE_CLKS(CYC)) i_page_commit_buf (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .abort(abort),
        .wr_permit(wr_permit), .busy(busy), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (mem_we) begin
            shadow[mem_waddr] = mem_wdata;
            wr_cnt++;
            if (int'(mem_waddr[3:0]) <= prev_off) order_bad++;
            prev_off = int'(mem_waddr[3:0]);
        end
        if (!busy) prev_off = -1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic compare_all(input string req);
        int bad = 0;
        for (int a = 0; a < 256; a++) if (shadow[a] !== expm[a]) bad++;
        chk(req, bad, 0);
    endtask

    // Full transaction; same_cycle_stop puts last byte together with stop.
    task automatic run_txn(input int sa, input int cnt, input logic same_cycle_stop, input string req);
        logic [7:0]  stg [16];
        logic [15:0] loaded = '0;
        int          exp_wr = 0;
        int          blen = 0;
        for (int i = 0; i < cnt; i++) begin
            int p = (sa + i) % 16;
            stg[p] = 8'(sa * 3 + cnt * 7 + i * 13 + 5);
            loaded[p] = 1'b1;
        end
        for (int p = 0; p < 16; p++)
            if (loaded[p] && !deny[p]) begin
                expm[{sa[7:4], 4'(p)}] = stg[p];
                exp_wr++;
            end
        wr_cnt = 0;
        order_bad = 0;
        txn_start = 1'b1; start_addr = 8'(sa);
        @(negedge clk);
        txn_start = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            byte_vld = 1'b1;
            byte_data = 8'(sa * 3 + cnt * 7 + i * 13 + 5);
            if (same_cycle_stop && i == cnt - 1) stop = 1'b1;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        if (!same_cycle_stop) begin
            stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        chk({req, " R5 busy after stop"}, int'(busy), 1);
        while (busy && blen < CYC + 10) begin
            blen++;
            @(negedge clk);
        end
        chk({req, " R7 busy length"}, blen, CYC);
        chk({req, " R4 write count"}, wr_cnt, exp_wr);
        chk({req, " R5 ascending offsets"}, order_bad, 0);
        compare_all({req, " R2 R3 R6 array image"});
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            shadow[a] = 8'hEE;
            expm[a] = 8'hEE;
        end
        idle_cycles(2);
        // R1
        chk("R1 busy at reset", int'(busy), 0);
        chk("R1 mem_we at reset", int'(mem_we), 0);
        rst_n = 1'b1;
        idle_cycles(2);
        chk("R1 busy after reset", int'(busy), 0);

        // R2 R3 R4 R6: sweep start offsets and byte counts, varying pages and masks
        for (int s = 0; s < 16; s++) begin
            for (int c = 1; c <= 20; c++) begin
                int sa = ((s + c * 5) % 16) * 16 + s;
                deny = (c % 3 == 0) ? (16'h00F0 ^ (16'h1 << s)) : 16'h0000;
                run_txn(sa, c, 1'b0, "sweep");
            end
        end
        deny = '0;

        // R10: last byte together with stop
        run_txn(8'h37, 3, 1'b1, "R10 byte with stop");
        run_txn(8'hAF, 1, 1'b1, "R10 single byte with stop");

        // R9: abort mid-transaction
        wr_cnt = 0;
        txn_start = 1'b1; start_addr = 8'h50; @(negedge clk); txn_start = 1'b0;
        byte_vld = 1'b1; byte_data = 8'h11; @(negedge clk); byte_vld = 1'b0;
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk("R9 abort no busy", int'(busy), 0);
        idle_cycles(20);
        chk("R9 abort no writes", wr_cnt, 0);

        // R9: stop with no data byte
        txn_start = 1'b1; start_addr = 8'h60; @(negedge clk); txn_start = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk("R9 empty txn no busy", int'(busy), 0);
        idle_cycles(20);
        chk("R9 empty txn no writes", wr_cnt, 0);

        // R12: abort and stop in the same cycle
        txn_start = 1'b1; start_addr = 8'h70; @(negedge clk); txn_start = 1'b0;
        byte_vld = 1'b1; byte_data = 8'h22; @(negedge clk); byte_vld = 1'b0;
        abort = 1'b1; stop = 1'b1; @(negedge clk); abort = 1'b0; stop = 1'b0;
        chk("R12 abort wins busy", int'(busy), 0);
        idle_cycles(20);
        chk("R12 abort wins writes", wr_cnt, 0);
        compare_all("R12 array untouched");

        // R11: repeated start discards earlier bytes
        txn_start = 1'b1; start_addr = 8'h84; @(negedge clk); txn_start = 1'b0;
        byte_vld = 1'b1; byte_data = 8'h33; @(negedge clk);
        byte_data = 8'h34; @(negedge clk); byte_vld = 1'b0;
        txn_start = 1'b1; start_addr = 8'h9C; @(negedge clk); txn_start = 1'b0;
        byte_vld = 1'b1; byte_data = 8'h44; @(negedge clk); byte_vld = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        expm[8'h9C] = 8'h44;
        chk("R11 busy after restart", int'(busy), 1);
        idle_cycles(CYC + 2);
        chk("R11 one write only", wr_cnt, 1);
        compare_all("R11 array image");

        // R8: inputs ignored while busy
        wr_cnt = 0;
        txn_start = 1'b1; start_addr = 8'hC0; @(negedge clk); txn_start = 1'b0;
        byte_vld = 1'b1; byte_data = 8'h55; @(negedge clk); byte_vld = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        expm[8'hC0] = 8'h55;
        idle_cycles(2);
        txn_start = 1'b1; start_addr = 8'hD0; @(negedge clk); txn_start = 1'b0;
        byte_vld = 1'b1; byte_data = 8'h66; @(negedge clk); byte_vld = 1'b0;
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        idle_cycles(CYC);
        chk("R8 busy ended", int'(busy), 0);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        byte_vld = 1'b1; byte_data = 8'h77; @(negedge clk); byte_vld = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk("R8 no commit from busy-time input", int'(busy), 0);
        idle_cycles(5);
        chk("R8 write count", wr_cnt, 1);
        compare_all("R8 array image");

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule